// File: doc/BRIEF.md
# Descriptor DMA Command Sequencer

This block is a single-channel engine. It walks a chain of 16-byte command descriptors that sit in system memory. It reads the descriptor at its command pointer as four 32-bit little-endian words and decodes the opcode. Data-moving commands are passed to a device through a request/done handshake. Word load and store commands move between memory and the descriptor's command-dependent word. NOP and STOP only sequence the chain.

When an operation finishes, the engine checks the descriptor's own wait policy. Unless it must stall, it writes the channel status and the residual count back into the descriptor. It then applies the descriptor's interrupt policy, followed by its branch policy. Each conditional policy compares the device-status bits against a mask/value selector of its own.

Software, or a surrounding register block, drives the run level and the activation pulse. It also loads the command pointer while the channel is idle.

Top module: `desc_seq`

## Requirements
- R1: After reset, `cmd_ptr_o` is 0, `irq_o`, `mem_req_o` and `xfer_req_o` are low, and `status_o` holds only RUN (bit 15, equal to `run_i`) and the device bits in 3:0.
- R2: Fetching happens only while RUN and ACTIVE (bit 10) are both set. `wake_i` with RUN high sets WAKE (bit 12) and ACTIVE, and WAKE is cleared when the fetch begins. A pointer load is forced to a 16-byte boundary and is ignored while ACTIVE is set. A memory request holds its address until acknowledged.
- R3: Descriptor word 0 is {command, request count}, word 1 is the data address, word 2 is the dependent word and word 3 is {transfer status, residual}. Opcodes 0/1 (output more/last) and 2/3 (input more/last) raise `xfer_req_o` with the direction, address, count and last flag, and hold it until `xfer_done_i`. Writeback stores `status_o` into the upper half of word 3 and `xfer_resid_i` into its lower half. A last transfer clears FLUSH (bit 13) after the store.
- R4: A condition is true when (devstat & sel[19:16]) == (sel[3:0] & sel[19:16]). Interrupt, branch and wait each use their own select input.
- R5: The interrupt field, command bits 5:4, is coded 0 never, 1 if true, 2 if false and 3 always. A hit gives a one-cycle `irq_o` pulse after writeback.
- R6: The branch field, bits 3:2, uses the same coding. A hit loads the pointer from the dependent word (low 4 bits zero) and sets BT (bit 8). A miss adds 16 to the pointer and clears BT.
- R7: The wait field, bits 1:0, uses the same coding. While it holds, the engine stalls with no writeback and no pointer change. Once it stops holding, the operation completes.
- R8: STOP (opcode 7, and any opcode above 7) clears ACTIVE. It writes nothing back and leaves the pointer unchanged.
- R9: NOP (opcode 6) writes the status back, leaves the residual unchanged, and then applies the interrupt and branch policies.
- R10: The key is bits 10:8. A data or word command with key 4 kills the channel. So does a data transfer with a zero address or a key above 3, and a word command with key 5 or 7. A kill sets DEAD (bit 11), clears ACTIVE and pulses `irq_o`, with no writeback and no pointer change.
- R11: Word load (opcode 5) and word store (opcode 4) use count bit 2 for 4 bytes (address aligned to 4), else bit 1 for 2 bytes (aligned to 2), else 1 byte. They move the bytes between the addressed memory lanes and the low bytes of the dependent word. Keys 0-3 act as key 6. These commands clear FLUSH and always advance by 16.
- R12: Driving `run_i` low clears ACTIVE and DEAD on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Channel run level |
| act_set_i | input | 1 | Pulse that sets ACTIVE while running |
| wake_i | input | 1 | Pulse that sets WAKE and ACTIVE while running |
| flush_i | input | 1 | Pulse that sets FLUSH |
| cp_wr_i | input | 1 | Command pointer load strobe |
| cp_data_i | input | AW | Command pointer load value |
| devstat_i | input | SW | Device status bits |
| int_sel_i | input | 32 | Interrupt condition selector |
| br_sel_i | input | 32 | Branch condition selector |
| wait_sel_i | input | 32 | Wait condition selector |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_wstrb_o | output | 4 | Byte write strobes |
| mem_ack_i | input | 1 | Memory acknowledge, read data valid with it |
| mem_rdata_i | input | 32 | Read data |
| xfer_req_o | output | 1 | Device transfer request |
| xfer_out_o | output | 1 | 1 = memory to device |
| xfer_addr_o | output | AW | Transfer buffer address |
| xfer_len_o | output | 16 | Requested byte count |
| xfer_last_o | output | 1 | Last transfer of a frame |
| xfer_done_i | input | 1 | Transfer completed |
| xfer_resid_i | input | 16 | Remaining count at completion |
| irq_o | output | 1 | Interrupt pulse |
| status_o | output | 16 | Channel status word |
| cmd_ptr_o | output | AW | Command pointer |

## Verification
With a memory that acknowledges at once, an operation's timing is fixed. It takes four fetch cycles, one decode cycle, the device handshake or one memory cycle, one wait-evaluation cycle and four writeback cycles. The interrupt pulse and the pointer update follow one cycle after the last writeback word. A kill gives its interrupt and sets DEAD one cycle after decode. The bench does not count these cycles to the edge. It waits for ACTIVE to fall and then three more cycles before it reads memory, the pointer, the status or the interrupt count. The one exception is the stall case, which is sampled forty cycles into the stall.

// File: rtl/desc_seq_pkg.sv
package desc_seq_pkg;

   typedef enum logic [1:0] {
      MD_NEVER  = 2'd0,
      MD_IFTRUE = 2'd1,
      MD_IFFALS = 2'd2,
      MD_ALWAYS = 2'd3
   } mode_e;

   typedef enum logic [3:0] {
      OP_OUT_MORE = 4'd0,
      OP_OUT_LAST = 4'd1,
      OP_IN_MORE  = 4'd2,
      OP_IN_LAST  = 4'd3,
      OP_STORE    = 4'd4,
      OP_LOAD     = 4'd5,
      OP_NOP      = 4'd6,
      OP_STOP     = 4'd7
   } opc_e;

   // status word bit positions
   localparam int ST_RUN    = 15;
   localparam int ST_FLUSH  = 13;
   localparam int ST_WAKE   = 12;
   localparam int ST_DEAD   = 11;
   localparam int ST_ACTIVE = 10;
   localparam int ST_BT     = 8;

   // selector layout: mask field starts here, value field at bit 0
   localparam int SEL_MASK_LSB = 16;

   localparam logic [2:0] KEY_BAD  = 3'd4;
   localparam logic [2:0] KEY_REGS = 3'd5;
   localparam logic [2:0] KEY_DEV  = 3'd7;

   typedef struct packed {
      logic       xfer;
      logic       out;
      logic       last;
      logic       ls;
      logic       load;
      logic       nop;
      logic       stop;
      logic       kill;
      logic [2:0] size;
      logic [1:0] imode;
      logic [1:0] bmode;
      logic [1:0] wmode;
   } dec_t;

endpackage

// File: rtl/desc_seq_cond.sv
module desc_seq_cond
   import desc_seq_pkg::*;
#(
   parameter int SW = 4
) (
   input  logic [SW-1:0] devstat,
   input  logic [31:0]   sel,
   input  logic [1:0]    mode,
   output logic          hit
);
   logic [SW-1:0] msk;
   logic [SW-1:0] val;
   logic          cond;

   assign msk  = sel[SEL_MASK_LSB +: SW];
   assign val  = sel[SW-1:0];
   assign cond = ((devstat & msk) == (val & msk));

   always_comb begin
      unique case (mode)
         MD_NEVER:  hit = 1'b0;
         MD_IFTRUE: hit = cond;
         MD_IFFALS: hit = !cond;
         default:   hit = 1'b1;
      endcase
   end
endmodule

// File: rtl/desc_seq_decode.sv
module desc_seq_decode
   import desc_seq_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic [15:0]   cmd,
   input  logic [15:0]   reqcnt,
   input  logic [AW-1:0] daddr,
   output dec_t          dec,
   output logic [AW-1:0] ls_addr
);
   logic [3:0] opc;
   logic [2:0] key;

   assign opc = cmd[15:12];
   assign key = cmd[10:8];

   always_comb begin
      dec       = '0;
      dec.imode = cmd[5:4];
      dec.bmode = cmd[3:2];
      dec.wmode = cmd[1:0];
      case (opc)
         OP_OUT_MORE, OP_OUT_LAST, OP_IN_MORE, OP_IN_LAST: begin
            dec.xfer = 1'b1;
            dec.out  = (opc == OP_OUT_MORE) || (opc == OP_OUT_LAST);
            dec.last = opc[0];
            dec.kill = (daddr == '0) || (key > 3'd3);
         end
         OP_STORE, OP_LOAD: begin
            dec.ls   = 1'b1;
            dec.load = (opc == OP_LOAD);
            dec.kill = (key == KEY_BAD) || (key == KEY_REGS) || (key == KEY_DEV);
         end
         OP_NOP:  dec.nop  = 1'b1;
         default: dec.stop = 1'b1;
      endcase

      if (reqcnt[2])      dec.size = 3'd4;
      else if (reqcnt[1]) dec.size = 3'd2;
      else                dec.size = 3'd1;
   end

   always_comb begin
      ls_addr = daddr;
      if (reqcnt[2])      ls_addr[1:0] = 2'b00;
      else if (reqcnt[1]) ls_addr[0]   = 1'b0;
   end
endmodule

// File: rtl/desc_seq_lane.sv
module desc_seq_lane (
   input  logic [1:0]  boff,
   input  logic [2:0]  size,
   input  logic [31:0] rdata,
   input  logic [31:0] dep,
   output logic [31:0] merged,
   output logic [31:0] wdata,
   output logic [3:0]  wstrb
);
   logic [7:0]  rbyte;
   logic [15:0] rhalf;

   always_comb begin
      case (boff)
         2'd0:    rbyte = rdata[7:0];
         2'd1:    rbyte = rdata[15:8];
         2'd2:    rbyte = rdata[23:16];
         default: rbyte = rdata[31:24];
      endcase
      rhalf = boff[1] ? rdata[31:16] : rdata[15:0];
   end

   always_comb begin
      if (size[2]) begin
         merged = rdata;
         wdata  = dep;
         wstrb  = 4'hF;
      end else if (size[1]) begin
         merged = {dep[31:16], rhalf};
         wdata  = {dep[15:0], dep[15:0]};
         wstrb  = boff[1] ? 4'b1100 : 4'b0011;
      end else begin
         merged = {dep[31:8], rbyte};
         wdata  = {4{dep[7:0]}};
         wstrb  = 4'b0001 << boff;
      end
   end
endmodule

// File: rtl/desc_seq.sv
module desc_seq
   import desc_seq_pkg::*;
#(
   parameter int AW = 32,
   parameter int SW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_i,
   input  logic          act_set_i,
   input  logic          wake_i,
   input  logic          flush_i,
   input  logic          cp_wr_i,
   input  logic [AW-1:0] cp_data_i,
   input  logic [SW-1:0] devstat_i,
   input  logic [31:0]   int_sel_i,
   input  logic [31:0]   br_sel_i,
   input  logic [31:0]   wait_sel_i,
   output logic          mem_req_o,
   output logic          mem_we_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [31:0]   mem_wdata_o,
   output logic [3:0]    mem_wstrb_o,
   input  logic          mem_ack_i,
   input  logic [31:0]   mem_rdata_i,
   output logic          xfer_req_o,
   output logic          xfer_out_o,
   output logic [AW-1:0] xfer_addr_o,
   output logic [15:0]   xfer_len_o,
   output logic          xfer_last_o,
   input  logic          xfer_done_i,
   input  logic [15:0]   xfer_resid_i,
   output logic          irq_o,
   output logic [15:0]   status_o,
   output logic [AW-1:0] cmd_ptr_o
);
   localparam int DESC_WORDS = 4;
   localparam int WIX        = $clog2(DESC_WORDS);
   localparam int DESC_BYTES = DESC_WORDS * 4;
   localparam int NCOND      = 3;

   if (AW < 8 || AW > 32) begin : g_bad_aw
      $error("desc_seq: AW must lie in 8..32");
   end
   if (SW < 1 || SW > 8) begin : g_bad_sw
      $error("desc_seq: SW must lie in 1..8");
   end

   typedef enum logic [2:0] {
      S_IDLE, S_FETCH, S_EXEC, S_XFER, S_LSMEM, S_WAIT, S_WB, S_POST
   } st_e;

   st_e            state;
   logic [31:0]    dw [DESC_WORDS];
   logic [WIX-1:0] wcnt;
   logic [AW-1:0]  cmd_ptr;
   logic           active, dead, bt, wake, flush, irq_q;
   logic [15:0]    st;

   dec_t           dec;
   logic [AW-1:0]  ls_addr;
   logic [31:0]    ln_merged, ln_wdata;
   logic [3:0]     ln_strb;

   logic [NCOND-1:0][31:0] c_sel;
   logic [NCOND-1:0][1:0]  c_mode;
   logic [NCOND-1:0]       c_hit;
   logic                   int_hit, br_hit, wait_hit;

   // ---------------- status word ----------------
   always_comb begin
      st            = '0;
      st[ST_RUN]    = run_i;
      st[ST_FLUSH]  = flush;
      st[ST_WAKE]   = wake;
      st[ST_DEAD]   = dead;
      st[ST_ACTIVE] = active;
      st[ST_BT]     = bt;
      st[SW-1:0]    = devstat_i;
   end

   // ---------------- decode and helpers ----------------
   desc_seq_decode #(.AW(AW)) u_dec (
      .cmd    (dw[0][31:16]),
      .reqcnt (dw[0][15:0]),
      .daddr  (dw[1][AW-1:0]),
      .dec    (dec),
      .ls_addr(ls_addr)
   );

   desc_seq_lane u_lane (
      .boff  (ls_addr[1:0]),
      .size  (dec.size),
      .rdata (mem_rdata_i),
      .dep   (dw[2]),
      .merged(ln_merged),
      .wdata (ln_wdata),
      .wstrb (ln_strb)
   );

   assign c_sel[0]  = int_sel_i;
   assign c_sel[1]  = br_sel_i;
   assign c_sel[2]  = wait_sel_i;
   assign c_mode[0] = dec.imode;
   assign c_mode[1] = dec.bmode;
   assign c_mode[2] = dec.wmode;

   for (genvar g = 0; g < NCOND; g++) begin : g_cond
      desc_seq_cond #(.SW(SW)) u_cond (
         .devstat(devstat_i),
         .sel    (c_sel[g]),
         .mode   (c_mode[g]),
         .hit    (c_hit[g])
      );
   end

   assign int_hit  = c_hit[0];
   assign br_hit   = c_hit[1];
   assign wait_hit = c_hit[2];

   // ---------------- port drive ----------------
   always_comb begin
      mem_req_o   = 1'b0;
      mem_we_o    = 1'b0;
      mem_addr_o  = cmd_ptr + AW'({wcnt, 2'b00});
      mem_wdata_o = dw[wcnt];
      mem_wstrb_o = 4'hF;
      case (state)
         S_FETCH: mem_req_o = 1'b1;
         S_LSMEM: begin
            mem_req_o   = 1'b1;
            mem_we_o    = !dec.load;
            mem_addr_o  = {ls_addr[AW-1:2], 2'b00};
            mem_wdata_o = ln_wdata;
            mem_wstrb_o = dec.load ? 4'hF : ln_strb;
         end
         S_WB: begin
            mem_req_o = 1'b1;
            mem_we_o  = 1'b1;
         end
         default: ;
      endcase
   end

   assign xfer_req_o  = (state == S_XFER);
   assign xfer_out_o  = dec.out;
   assign xfer_addr_o = dw[1][AW-1:0];
   assign xfer_len_o  = dw[0][15:0];
   assign xfer_last_o = dec.last;
   assign irq_o       = irq_q;
   assign status_o    = st;
   assign cmd_ptr_o   = cmd_ptr;

   // ---------------- sequencer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         wcnt    <= '0;
         cmd_ptr <= '0;
         active  <= 1'b0;
         dead    <= 1'b0;
         bt      <= 1'b0;
         wake    <= 1'b0;
         flush   <= 1'b0;
         irq_q   <= 1'b0;
         for (int i = 0; i < DESC_WORDS; i++) dw[i] <= '0;
      end else begin
         irq_q <= 1'b0;
         case (state)
            S_IDLE: begin
               if (run_i && active) begin
                  state <= S_FETCH;
                  wcnt  <= '0;
                  wake  <= 1'b0;
               end
            end
            S_FETCH: begin
               if (mem_ack_i) begin
                  dw[wcnt] <= mem_rdata_i;
                  if (wcnt == WIX'(DESC_WORDS - 1)) state <= S_EXEC;
                  else wcnt <= wcnt + 1'b1;
               end
            end
            S_EXEC: begin
               if (!run_i || !active) begin
                  state <= S_IDLE;
               end else if (dec.stop) begin
                  active <= 1'b0;
                  state  <= S_IDLE;
               end else if (dec.kill) begin
                  dead   <= 1'b1;
                  active <= 1'b0;
                  irq_q  <= 1'b1;
                  state  <= S_IDLE;
               end else if (dec.xfer) begin
                  state <= S_XFER;
               end else if (dec.ls) begin
                  state <= S_LSMEM;
               end else begin
                  state <= S_WAIT;
               end
            end
            S_XFER: begin
               if (xfer_done_i) begin
                  dw[3][15:0] <= xfer_resid_i;
                  state       <= S_WAIT;
               end
            end
            S_LSMEM: begin
               if (mem_ack_i) begin
                  if (dec.load) dw[2] <= ln_merged;
                  state <= S_WAIT;
               end
            end
            S_WAIT: begin
               if (!run_i || !active) begin
                  state <= S_IDLE;
               end else if (!wait_hit) begin
                  dw[3][31:16] <= st;
                  if (dec.ls || (dec.xfer && dec.last)) flush <= 1'b0;
                  wcnt  <= '0;
                  state <= S_WB;
               end
            end
            S_WB: begin
               if (mem_ack_i) begin
                  if (wcnt == WIX'(DESC_WORDS - 1)) state <= S_POST;
                  else wcnt <= wcnt + 1'b1;
               end
            end
            S_POST: begin
               irq_q <= int_hit;
               if (!dec.ls && br_hit) begin
                  cmd_ptr <= {dw[2][AW-1:4], 4'b0000};
                  bt      <= 1'b1;
               end else begin
                  cmd_ptr <= cmd_ptr + AW'(DESC_BYTES);
                  bt      <= 1'b0;
               end
               state <= S_IDLE;
            end
            default: state <= S_IDLE;
         endcase

         // software-side controls take precedence over the sequencer
         if (!run_i) begin
            active <= 1'b0;
            dead   <= 1'b0;
         end else if (act_set_i || wake_i) begin
            active <= 1'b1;
         end
         if (wake_i && run_i) wake <= 1'b1;
         if (flush_i) flush <= 1'b1;
         if (cp_wr_i && !active) cmd_ptr <= {cp_data_i[AW-1:4], 4'b0000};
      end
   end
endmodule

// File: rtl/desc_seq_chk.sv
module desc_seq_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          run_i,
   input logic          irq_o,
   input logic [15:0]   status_o,
   input logic          mem_req_o,
   input logic          mem_ack_i,
   input logic [AW-1:0] mem_addr_o,
   input logic          xfer_req_o,
   input logic          xfer_done_i
);
   // R5
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);

   // R2
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

   // R3
   xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req_o && !xfer_done_i) |=> xfer_req_o);

   // R12
   run_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (!status_o[10] && !status_o[11]));

   // R10
   dead_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_o[11]) |-> (irq_o && !status_o[10]));
endmodule

bind desc_seq desc_seq_chk #(.AW(AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .run_i      (run_i),
   .irq_o      (irq_o),
   .status_o   (status_o),
   .mem_req_o  (mem_req_o),
   .mem_ack_i  (mem_ack_i),
   .mem_addr_o (mem_addr_o),
   .xfer_req_o (xfer_req_o),
   .xfer_done_i(xfer_done_i)
);

// File: tb/desc_seq_test.sv
module desc_seq_test;
   localparam int AW = 32;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n = 1'b0;
   logic run_i = 1'b0, act_set_i = 1'b0, wake_i = 1'b0, flush_i = 1'b0, cp_wr_i = 1'b0;
   logic [AW-1:0] cp_data_i = '0;
   logic [3:0]  devstat_i = '0;
   logic [31:0] int_sel_i = '0, br_sel_i = '0, wait_sel_i = '0;
   logic mem_req_o, mem_we_o, mem_ack_i;
   logic [AW-1:0] mem_addr_o;
   logic [31:0] mem_wdata_o, mem_rdata_i;
   logic [3:0]  mem_wstrb_o;
   logic xfer_req_o, xfer_out_o, xfer_last_o;
   logic [AW-1:0] xfer_addr_o;
   logic [15:0] xfer_len_o;
   logic xfer_done_i = 1'b0;
   logic [15:0] xfer_resid_i = '0;
   logic irq_o;
   logic [15:0] status_o;
   logic [AW-1:0] cmd_ptr_o;

   desc_seq #(.AW(AW), .SW(4)) uut (.*);

   // ---------------- memory model ----------------
   logic [31:0] mem [256];
   logic        tb_we = 1'b0;
   logic [7:0]  tb_wa = '0;
   logic [31:0] tb_wd = '0;

   assign mem_ack_i   = mem_req_o;
   assign mem_rdata_i = mem[mem_addr_o[9:2]];

   always @(posedge clk) begin
      if (tb_we) mem[tb_wa] <= tb_wd;
      if (mem_req_o && mem_we_o)
         for (int b = 0; b < 4; b++)
            if (mem_wstrb_o[b]) mem[mem_addr_o[9:2]][8*b +: 8] <= mem_wdata_o[8*b +: 8];
   end

   // ---------------- device model ----------------
   int dcnt = 0;
   logic rec_out, rec_last;
   logic [31:0] rec_addr;
   logic [15:0] rec_len;
   always @(posedge clk) begin
      if (xfer_done_i) xfer_done_i <= 1'b0;
      else if (xfer_req_o) begin
         if (dcnt == 2) begin
            xfer_done_i  <= 1'b1;
            xfer_resid_i <= xfer_len_o >> 1;
            rec_out  <= xfer_out_o;
            rec_last <= xfer_last_o;
            rec_addr <= xfer_addr_o;
            rec_len  <= xfer_len_o;
            dcnt     <= 0;
         end else dcnt <= dcnt + 1;
      end
   end

   int irq_cnt = 0;
   always @(posedge clk) if (irq_o) irq_cnt++;

   int checks = 0, errors = 0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] cmdw(int op, int key, int im, int bm, int wm);
      return {op[3:0], 1'b0, key[2:0], 2'b00, im[1:0], bm[1:0], wm[1:0]};
   endfunction

   function automatic bit bcond(logic [3:0] ds, logic [31:0] sel);
      return (ds & sel[19:16]) == (sel[3:0] & sel[19:16]);
   endfunction

   function automatic bit bhit(int md, bit c);
      case (md)
         0: return 1'b0;
         1: return c;
         2: return !c;
         default: return 1'b1;
      endcase
   endfunction

   task automatic put(int a, logic [31:0] v);
      @(negedge clk);
      tb_we = 1'b1; tb_wa = a[9:2]; tb_wd = v;
      @(negedge clk);
      tb_we = 1'b0;
   endtask

   task automatic desc(int a, logic [15:0] c, logic [15:0] n, logic [31:0] da,
                       logic [31:0] dep, logic [31:0] w3);
      put(a, {c, n}); put(a + 4, da); put(a + 8, dep); put(a + 12, w3);
   endtask

   task automatic set_ptr(int a);
      @(negedge clk); cp_wr_i = 1'b1; cp_data_i = a;
      @(negedge clk); cp_wr_i = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (!status_o[10]) break;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic go();
      @(negedge clk); act_set_i = 1'b1;
      @(negedge clk); act_set_i = 1'b0;
      wait_idle();
   endtask

   task automatic kill_case(int a, logic [15:0] c, logic [15:0] n, logic [31:0] da, string tag);
      int i0;
      desc(a, c, n, da, 32'h0, 32'h77777777);
      set_ptr(a);
      i0 = irq_cnt;
      go();
      chk({"R10 dead ", tag}, status_o[11], 1'b1);
      chk({"R10 active ", tag}, status_o[10], 1'b0);
      chk({"R10 irq ", tag}, irq_cnt - i0, 1);
      chk({"R10 ptr ", tag}, cmd_ptr_o, a);
      chk({"R10 no writeback ", tag}, mem[(a + 12) >> 2], 32'h77777777);
      @(negedge clk); run_i = 1'b0;
      @(negedge clk);
      chk({"R12 dead cleared ", tag}, status_o[11], 1'b0);
      run_i = 1'b1;
   endtask

   initial begin
      int i0;
      void'($urandom(32'd1234));
      for (int i = 0; i < 256; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 status", status_o, 16'h0000);
      chk("R1 cmd_ptr", cmd_ptr_o, 0);
      chk("R1 outputs", {irq_o, mem_req_o, xfer_req_o}, 3'b000);

      // R2 pointer alignment, no fetch without ACTIVE
      set_ptr(32'h107);
      chk("R2 ptr aligned", cmd_ptr_o, 32'h100);
      run_i = 1'b1;
      i0 = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (mem_req_o) i0++;
      end
      chk("R2 no fetch while inactive", i0, 0);

      // directed chain
      mem[32'h2A0 >> 2] = 32'hDEADBEEF;
      mem[32'h2B0 >> 2] = 32'h01020304;
      desc(32'h100, cmdw(1, 0, 3, 0, 0), 16'd40, 32'h200, 32'h0, 32'h0);
      desc(32'h110, cmdw(6, 0, 1, 3, 0), 16'd0, 32'h0, 32'h180, 32'h0);
      desc(32'h180, cmdw(5, 6, 0, 3, 0), 16'd2, 32'h2A3, 32'h11112222, 32'h0);
      desc(32'h190, cmdw(4, 0, 0, 0, 0), 16'd1, 32'h2B1, 32'h0000005A, 32'h0);
      desc(32'h1A0, cmdw(7, 0, 0, 0, 0), 16'd0, 32'h0, 32'h0, 32'h55555555);
      devstat_i = 4'h5;
      int_sel_i = 32'h0003_0001;
      i0 = irq_cnt;
      @(negedge clk); flush_i = 1'b1;
      @(negedge clk); flush_i = 1'b0;
      @(negedge clk); wake_i = 1'b1;
      @(negedge clk); wake_i = 1'b0;
      for (int i = 0; i < 200; i++) begin
         if (xfer_req_o) break;
         @(negedge clk);
      end
      @(negedge clk); cp_wr_i = 1'b1; cp_data_i = 32'h300;
      @(negedge clk); cp_wr_i = 1'b0;
      wait_idle();
      chk("R3 dir/last", {rec_out, rec_last}, 2'b11);
      chk("R3 addr", rec_addr, 32'h200);
      chk("R3 len", rec_len, 16'd40);
      chk("R3 status+resid (R2 wake cleared)", mem[32'h10C >> 2], 32'hA405_0014);
      chk("R9 nop writeback after flush clear", mem[32'h11C >> 2], 32'h8405_0000);
      chk("R6 bt in status after branch", mem[32'h18C >> 2], 32'h8505_0000);
      chk("R11 load half", mem[32'h188 >> 2], 32'h1111DEAD);
      chk("R11 store byte", mem[32'h2B0 >> 2], 32'h01025A04);
      chk("R11 store status", mem[32'h19C >> 2], 32'h8405_0000);
      chk("R5 irq count", irq_cnt - i0, 2);
      chk("R8 stop ptr (R2 ptr write ignored)", cmd_ptr_o, 32'h1A0);
      chk("R8 stop no writeback", mem[32'h1AC >> 2], 32'h55555555);
      chk("R6 bt cleared by next", status_o[8], 1'b0);

      // R7 wait stall
      desc(32'h340, cmdw(6, 0, 0, 0, 1), 16'd0, 32'h0, 32'h0, 32'h66666666);
      desc(32'h350, cmdw(7, 0, 0, 0, 0), 16'd0, 32'h0, 32'h0, 32'h0);
      wait_sel_i = 32'h000F_0003;
      devstat_i = 4'h3;
      set_ptr(32'h340);
      @(negedge clk); act_set_i = 1'b1;
      @(negedge clk); act_set_i = 1'b0;
      repeat (40) @(negedge clk);
      chk("R7 stalled no writeback", mem[32'h34C >> 2], 32'h66666666);
      chk("R7 stalled active", status_o[10], 1'b1);
      chk("R7 stalled ptr", cmd_ptr_o, 32'h340);
      devstat_i = 4'h0;
      wait_idle();
      chk("R7 released writeback", {mem[32'h34C >> 2][31:16] & 16'hFEFF, mem[32'h34C >> 2][15:0]},
          32'h8400_6666);
      chk("R7 released ptr", cmd_ptr_o, 32'h350);
      wait_sel_i = '0;

      // R10 kills
      kill_case(32'h300, cmdw(0, 4, 0, 0, 0), 16'd8, 32'h200, "key4");
      kill_case(32'h310, cmdw(2, 0, 0, 0, 0), 16'd8, 32'h0, "zero addr");
      kill_case(32'h320, cmdw(5, 5, 0, 0, 0), 16'd4, 32'h200, "ls key5");

      // random NOP policies
      for (int it = 0; it < 40; it++) begin
         int im, bm;
         bit ebr, eirq, pbt;
         logic [3:0] ds;
         im = $urandom_range(0, 3);
         bm = $urandom_range(0, 3);
         ds = 4'($urandom_range(0, 15));
         int_sel_i = $urandom;
         br_sel_i  = $urandom;
         devstat_i = ds;
         eirq = bhit(im, bcond(ds, int_sel_i));
         ebr  = bhit(bm, bcond(ds, br_sel_i));
         pbt  = status_o[8];
         desc(32'h040, cmdw(6, 0, im, bm, 0), 16'd0, 32'h0, 32'h80, 32'h0);
         desc(32'h050, cmdw(7, 0, 0, 0, 0), 16'd0, 32'h0, 32'h0, 32'h0);
         desc(32'h080, cmdw(7, 0, 0, 0, 0), 16'd0, 32'h0, 32'h0, 32'h0);
         set_ptr(32'h040);
         i0 = irq_cnt;
         go();
         chk("R4 R6 random branch ptr", cmd_ptr_o, ebr ? 32'h80 : 32'h50);
         chk("R6 random bt", status_o[8], ebr);
         chk("R5 random irq", irq_cnt - i0, eirq);
         chk("R9 random status", mem[32'h04C >> 2], {16'h8400 | (16'(pbt) << 8) | 16'(ds), 16'h0});
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule